// File: doc/BRIEF.md
# Memory Dependence Scheduler

This block sits beside the memory half of an out-of-order issue window and decides when each in-flight load or store may be handed to the issue logic. Every operation is held in a small table keyed by its sequence number. When an operation is inserted, the block works out which older operation it must wait for. That producer is the active barrier that applies to its type, or failing that, the store named by an external dependence predictor. A waiting operation is released when its producer leaves the table. An operation is presented on the ready output only when both its memory dependence and its source registers are satisfied.

The block also handles barriers, non-speculative operations and rescheduled operations. Two barrier flags hold the sequence number of the youngest full barrier and the youngest write barrier. Non-speculative operations wait for an explicit go. Rescheduled operations sit in an ordered replay queue until a replay request releases the whole queue. A squash for one thread removes all of that thread's operations younger than a given sequence number, in a single cycle.

The block takes one command per cycle on a single command port. Its one output is a valid/ready channel that offers one sequence number at a time.

Top module: `memdep_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the table is empty, both barrier flags are clear and rdy_valid is 0.
- R2: A barrier insert (cmd_op 3) behaves according to cmd_kind. With cmd_kind 2 (full barrier), it records its sequence number in both the load-barrier flag and the store-barrier flag. With cmd_kind 3 (write barrier), it records its sequence number in the store-barrier flag only, and loads inserted afterwards are not held by it.
- R3: A normal insert (cmd_op 1) picks its producer as follows. A load (cmd_kind 0) uses the load-barrier sequence number when that flag is set. A store (cmd_kind 1) uses the store-barrier sequence number when that flag is set. In every other case the producer is pred_seq.
- R4: An insert has no dependence when its producer is zero, or is not in the table, or names a table entry that is a load. Such an entry is marked memory-ready, and if cmd_regs_rdy was 1 it is offered on the ready output in the next cycle.
- R5: An insert whose producer is a store or barrier in the table is not offered. When that producer leaves the table (cmd_op 8 complete, or a squash), the waiter is offered at once if its registers are ready. Otherwise the waiter is only marked memory-ready.
- R6: A register-ready command (cmd_op 4) offers the entry only if it is already memory-ready. Otherwise it only records register readiness.
- R7: Completing a barrier clears each barrier flag only if that flag still holds the completing barrier's sequence number. A flag taken over by a younger barrier stays set.
- R8: A reschedule (cmd_op 6) appends the entry to the replay queue. A replay (cmd_op 7) offers every queued entry in append order and empties the queue.
- R9: A squash (cmd_op 9) removes every entry of thread cmd_tid whose sequence number is greater than cmd_seq, and also drops those entries from the replay queue. Entries of other threads, and entries at or below the squash point, are kept.
- R10: rdy_seq names a live table entry whenever rdy_valid is 1, and an entry leaves the output when rdy_valid and rdy_ready are both 1. Replayed entries are offered before other ready entries. Other ready entries are offered lowest table slot first, where an insert takes the lowest free slot.
- R11: A non-speculative insert (cmd_op 2) is never offered until a non-speculative go (cmd_op 5) names it, even when its registers are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code (0 idle, 1 insert, 2 non-speculative insert, 3 barrier insert, 4 registers ready, 5 non-speculative go, 6 reschedule, 7 replay, 8 complete, 9 squash) |
| cmd_seq | input | SEQ_W | Sequence number of the operation, or the squash point |
| cmd_tid | input | TID_W | Thread of the operation or of the squash |
| cmd_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_regs_rdy | input | 1 | Source registers already ready at insert |
| pred_seq | input | SEQ_W | Producer sequence number from the predictor, zero for none |
| rdy_valid | output | 1 | An operation is offered for issue |
| rdy_ready | input | 1 | The issue logic accepts the offered operation |
| rdy_seq | output | SEQ_W | Sequence number of the offered operation |

## Verification
Every command is registered at one rising edge, and its effect on rdy_valid and rdy_seq can be seen right after that edge. This covers an immediate offer, an offer from a wakeup, the start of a replay and the removal of squashed entries. The bench drives each command at a falling edge and checks the output at the next falling edge, so every result is sampled exactly one cycle after its stimulus. An accepted offer is removed at the edge where rdy_ready is high, and the next falling-edge sample already shows the next candidate. The sweep covers every combination of operation type, barrier state, predictor answer and register readiness. Directed sequences then check the barrier hand-over, replay order and squash boundaries.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

   typedef enum logic [3:0] {
      OP_NOP       = 4'd0,
      OP_INSERT    = 4'd1,
      OP_INSERT_NS = 4'd2,
      OP_BARRIER   = 4'd3,
      OP_REGS_RDY  = 4'd4,
      OP_NS_GO     = 4'd5,
      OP_RESCHED   = 4'd6,
      OP_REPLAY    = 4'd7,
      OP_COMPLETE  = 4'd8,
      OP_SQUASH    = 4'd9
   } mdu_op_e;

   typedef enum logic [1:0] {
      K_LOAD  = 2'd0,
      K_STORE = 2'd1,
      K_FULLB = 2'd2,
      K_WRB   = 2'd3
   } mdu_kind_e;

endpackage

// File: rtl/memdep_pick.sv
module memdep_pick #(
   parameter int N          = 16,
   parameter bit HIGH_FIRST = 1'b0,
   localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   initial begin
      if (N < 2) $fatal(1, "memdep_pick: N must be at least 2");
   end

   assign any = |req;

   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (req[i]) idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (req[i]) idx = IW'(i);
         end
      end
   endgenerate

endmodule

// File: rtl/memdep_cam.sv
module memdep_cam #(
   parameter int N     = 16,
   parameter int SEQ_W = 16,
   localparam int IW   = $clog2(N)
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0][SEQ_W-1:0] seq,
   input  logic [SEQ_W-1:0]        key,
   output logic [N-1:0]            hit,
   output logic                    any,
   output logic [IW-1:0]           idx
);

   initial begin
      if (SEQ_W < 2) $fatal(1, "memdep_cam: SEQ_W must be at least 2");
   end

   // zero is never a real sequence number
   always_comb begin
      for (int i = 0; i < N; i++)
         hit[i] = valid[i] && (seq[i] == key) && (key != '0);
   end

   memdep_pick #(.N(N), .HIGH_FIRST(1'b0)) u_pick (
      .req (hit),
      .any (any),
      .idx (idx)
   );

endmodule

// File: rtl/memdep_rank.sv
module memdep_rank #(
   parameter int N   = 16,
   localparam int IW = $clog2(N),
   localparam int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]         keep,
   input  logic [N-1:0][IW-1:0] rank,
   output logic [N-1:0][IW-1:0] new_rank,
   output logic [CW-1:0]        keep_count
);

   logic [N-1:0][CW-1:0] older;

   // position of each survivor = number of surviving entries ahead of it
   always_comb begin
      for (int i = 0; i < N; i++) begin
         older[i] = '0;
         for (int j = 0; j < N; j++)
            older[i] = older[i] + CW'(keep[j] && (rank[j] < rank[i]));
         new_rank[i] = older[i][IW-1:0];
      end
   end

   always_comb begin
      keep_count = '0;
      for (int j = 0; j < N; j++)
         keep_count = keep_count + CW'(keep[j]);
   end

endmodule

// File: rtl/memdep_sched.sv
module memdep_sched
   import memdep_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int SEQ_W   = 16,
   parameter int TID_W   = 1,
   localparam int IW     = $clog2(ENTRIES),
   localparam int CW     = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [SEQ_W-1:0] cmd_seq,
   input  logic [TID_W-1:0] cmd_tid,
   input  logic [1:0]       cmd_kind,
   input  logic             cmd_regs_rdy,
   input  logic [SEQ_W-1:0] pred_seq,
   output logic             rdy_valid,
   input  logic             rdy_ready,
   output logic [SEQ_W-1:0] rdy_seq
);

   initial begin
      if (ENTRIES < 2 || (1 << IW) != ENTRIES)
         $fatal(1, "memdep_sched: ENTRIES must be a power of two >= 2");
      if (TID_W < 1) $fatal(1, "memdep_sched: TID_W must be >= 1");
   end

   // ---------------- entry state ----------------
   logic [ENTRIES-1:0]            e_valid, e_regs, e_mem, e_hasp;
   logic [ENTRIES-1:0]            e_pend, e_rsq, e_go;
   logic [ENTRIES-1:0][SEQ_W-1:0] e_seq;
   logic [ENTRIES-1:0][TID_W-1:0] e_tid;
   logic [ENTRIES-1:0][1:0]       e_kind;
   logic [ENTRIES-1:0][IW-1:0]    e_prod, e_rank;

   logic             lb_act, sb_act;
   logic [SEQ_W-1:0] lb_seq, sb_seq;

   mdu_op_e op;
   assign op = mdu_op_e'(cmd_op);

   // ---------------- slot allocation ----------------
   logic          free_any;
   logic [IW-1:0] free_idx;
   logic          is_ins, ins_ok;

   memdep_pick #(.N(ENTRIES), .HIGH_FIRST(1'b0)) u_free (
      .req (~e_valid),
      .any (free_any),
      .idx (free_idx)
   );

   assign is_ins = cmd_valid && (op == OP_INSERT || op == OP_INSERT_NS || op == OP_BARRIER);
   assign ins_ok = is_ins && free_any;

   // ---------------- lookup of the command's own entry ----------------
   logic [ENTRIES-1:0] cmd_hit;
   logic               cmd_hit_any;
   logic [IW-1:0]      cmd_idx;

   memdep_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_cmd_cam (
      .valid (e_valid),
      .seq   (e_seq),
      .key   (cmd_seq),
      .hit   (cmd_hit),
      .any   (cmd_hit_any),
      .idx   (cmd_idx)
   );

   // ---------------- producer selection and lookup ----------------
   logic [SEQ_W-1:0]   prod_key;
   logic [ENTRIES-1:0] prod_cap, prod_hit;
   logic               prod_found;
   logic [IW-1:0]      prod_idx;

   always_comb begin
      if (cmd_kind == K_LOAD && lb_act)       prod_key = lb_seq;
      else if (cmd_kind == K_STORE && sb_act) prod_key = sb_seq;
      else                                    prod_key = pred_seq;
   end

   // only stores and barriers can hold waiters
   always_comb begin
      for (int i = 0; i < ENTRIES; i++)
         prod_cap[i] = e_valid[i] && (e_kind[i] != K_LOAD);
   end

   memdep_cam #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_prod_cam (
      .valid (prod_cap),
      .seq   (e_seq),
      .key   (prod_key),
      .hit   (prod_hit),
      .any   (prod_found),
      .idx   (prod_idx)
   );

   // ---------------- output selection ----------------
   logic [ENTRIES-1:0] head_v;
   logic               rp_any, pd_any, fire, pop_rp, pop_pd;
   logic [IW-1:0]      rp_idx, pd_idx, out_idx;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++)
         head_v[i] = e_valid[i] && e_rsq[i] && e_go[i] && (e_rank[i] == '0);
   end

   memdep_pick #(.N(ENTRIES), .HIGH_FIRST(1'b0)) u_head (
      .req (head_v),
      .any (rp_any),
      .idx (rp_idx)
   );

   memdep_pick #(.N(ENTRIES), .HIGH_FIRST(1'b0)) u_pend (
      .req (e_pend & e_valid),
      .any (pd_any),
      .idx (pd_idx)
   );

   assign out_idx   = rp_any ? rp_idx : pd_idx;
   assign rdy_valid = rp_any || pd_any;
   assign rdy_seq   = e_seq[out_idx];
   assign fire      = rdy_valid && rdy_ready;
   assign pop_rp    = fire && rp_any;
   assign pop_pd    = fire && !rp_any;

   // ---------------- removal and wakeup ----------------
   logic [ENTRIES-1:0] kill, wake, keep_rq;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         kill[i] = 1'b0;
         if (cmd_valid && op == OP_COMPLETE && cmd_hit[i]) kill[i] = 1'b1;
         if (cmd_valid && op == OP_SQUASH && e_valid[i] && e_tid[i] == cmd_tid &&
             e_seq[i] > cmd_seq) kill[i] = 1'b1;
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         wake[i]    = e_valid[i] && e_hasp[i] && kill[e_prod[i]] && !kill[i];
         keep_rq[i] = e_rsq[i] && !kill[i] && !(pop_rp && rp_idx == IW'(i));
      end
   end

   logic [ENTRIES-1:0][IW-1:0] nrank;
   logic [CW-1:0]              kcount;

   memdep_rank #(.N(ENTRIES)) u_rank (
      .keep       (keep_rq),
      .rank       (e_rank),
      .new_rank   (nrank),
      .keep_count (kcount)
   );

   // ---------------- entry update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= '0; e_regs <= '0; e_mem <= '0; e_hasp <= '0;
         e_pend  <= '0; e_rsq  <= '0; e_go  <= '0;
         e_seq   <= '0; e_tid  <= '0; e_kind <= '0;
         e_prod  <= '0; e_rank <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (kill[i]) begin
               e_valid[i] <= 1'b0;
               e_pend[i]  <= 1'b0;
               e_rsq[i]   <= 1'b0;
               e_go[i]    <= 1'b0;
               e_hasp[i]  <= 1'b0;
            end else if (ins_ok && free_idx == IW'(i)) begin
               e_valid[i] <= 1'b1;
               e_seq[i]   <= cmd_seq;
               e_tid[i]   <= cmd_tid;
               e_kind[i]  <= cmd_kind;
               e_rsq[i]   <= 1'b0;
               e_go[i]    <= 1'b0;
               e_rank[i]  <= '0;
               e_prod[i]  <= prod_idx;
               e_regs[i]  <= cmd_regs_rdy && (op != OP_BARRIER);
               if (op == OP_INSERT && !prod_found) begin
                  e_hasp[i] <= 1'b0;
                  e_mem[i]  <= 1'b1;
                  e_pend[i] <= cmd_regs_rdy;
               end else begin
                  e_hasp[i] <= (op == OP_INSERT);
                  e_mem[i]  <= 1'b0;
                  e_pend[i] <= 1'b0;
               end
            end else if (e_valid[i]) begin
               e_rank[i] <= nrank[i];
               if (wake[i]) begin
                  e_hasp[i] <= 1'b0;
                  e_mem[i]  <= 1'b1;
                  if (e_regs[i]) e_pend[i] <= 1'b1;
               end
               if (cmd_valid && cmd_hit[i]) begin
                  case (op)
                     OP_REGS_RDY: begin
                        e_regs[i] <= 1'b1;
                        if (e_mem[i]) e_pend[i] <= 1'b1;
                     end
                     OP_NS_GO: e_pend[i] <= 1'b1;
                     OP_RESCHED: if (!e_rsq[i]) begin
                        e_rsq[i]  <= 1'b1;
                        e_go[i]   <= 1'b0;
                        e_rank[i] <= kcount[IW-1:0];
                     end
                     default: ;
                  endcase
               end
               if (cmd_valid && op == OP_REPLAY && e_rsq[i]) e_go[i] <= 1'b1;
               if (e_rsq[i] && !keep_rq[i]) begin
                  e_rsq[i] <= 1'b0;
                  e_go[i]  <= 1'b0;
               end
               if (pop_pd && pd_idx == IW'(i)) e_pend[i] <= 1'b0;
            end
         end
      end
   end

   // ---------------- barrier flags ----------------
   logic cmp_bar;
   assign cmp_bar = cmd_valid && op == OP_COMPLETE && cmd_hit_any &&
                    (e_kind[cmd_idx] == K_FULLB || e_kind[cmd_idx] == K_WRB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lb_act <= 1'b0; sb_act <= 1'b0;
         lb_seq <= '0;   sb_seq <= '0;
      end else if (ins_ok && op == OP_BARRIER) begin
         if (cmd_kind == K_FULLB) begin
            lb_act <= 1'b1; lb_seq <= cmd_seq;
            sb_act <= 1'b1; sb_seq <= cmd_seq;
         end else if (cmd_kind == K_WRB) begin
            sb_act <= 1'b1; sb_seq <= cmd_seq;
         end
      end else if (cmp_bar) begin
         if (lb_seq == cmd_seq) lb_act <= 1'b0;
         if (sb_seq == cmd_seq) sb_act <= 1'b0;
      end
   end

   // ---------------- assertions ----------------
   p_full_bar_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_ok && op == OP_BARRIER && cmd_kind == K_FULLB) |=>
      (lb_act && sb_act && lb_seq == $past(cmd_seq) && sb_seq == $past(cmd_seq)));

   p_wr_bar_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_ok && op == OP_BARRIER && cmd_kind == K_WRB) |=>
      (sb_act && sb_seq == $past(cmd_seq) && $stable(lb_act)));

   p_nodep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_ok && op == OP_INSERT && !prod_found && cmd_regs_rdy) |=> rdy_valid);

   p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_ok && op == OP_INSERT && prod_found) |=>
      (!e_pend[$past(free_idx)] && !e_mem[$past(free_idx)]));

   p_bar_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_COMPLETE && cmd_hit_any && sb_act && sb_seq == cmd_seq) |=> !sb_act);

   p_out_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_valid |-> e_valid[out_idx]);

   // squash leaves nothing younger in the squashed thread
   logic             sq_q;
   logic [TID_W-1:0] sq_tid_q;
   logic [SEQ_W-1:0] sq_pt_q;
   logic             young_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq_q <= 1'b0; sq_tid_q <= '0; sq_pt_q <= '0;
      end else begin
         sq_q     <= cmd_valid && op == OP_SQUASH;
         sq_tid_q <= cmd_tid;
         sq_pt_q  <= cmd_seq;
      end
   end

   always_comb begin
      young_left = 1'b0;
      for (int i = 0; i < ENTRIES; i++)
         if (e_valid[i] && e_tid[i] == sq_tid_q && e_seq[i] > sq_pt_q) young_left = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst_n && sq_q) begin
         p_squash_r9: assert (!young_left);
      end
   end

endmodule

// File: tb/memdep_sched_bench.sv
module memdep_sched_bench;
   import memdep_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [15:0] cmd_seq = '0;
   logic [0:0]  cmd_tid = '0;
   logic [1:0]  cmd_kind = '0;
   logic        cmd_regs_rdy = 1'b0;
   logic [15:0] pred_seq = '0;
   logic        rdy_valid;
   logic        rdy_ready = 1'b0;
   logic [15:0] rdy_seq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   memdep_sched #(.ENTRIES(16), .SEQ_W(16), .TID_W(1)) u_memdep_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_seq      (cmd_seq),
      .cmd_tid      (cmd_tid),
      .cmd_kind     (cmd_kind),
      .cmd_regs_rdy (cmd_regs_rdy),
      .pred_seq     (pred_seq),
      .rdy_valid    (rdy_valid),
      .rdy_ready    (rdy_ready),
      .rdy_seq      (rdy_seq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp_v);
      end
   endtask

   function automatic int out_now();
      return rdy_valid ? int'(rdy_seq) : -1;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; cmd_valid = 1'b0; rdy_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd(input mdu_op_e o, input int s, input int t, input int k,
                      input bit r, input int p);
      cmd_op = o; cmd_seq = 16'(s); cmd_tid = 1'(t); cmd_kind = 2'(k);
      cmd_regs_rdy = r; pred_seq = 16'(p); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic expect_out(input int s, input string tag);
      check(rdy_valid && rdy_seq == 16'(s), tag, out_now(), s);
      rdy_ready = 1'b1;
      @(negedge clk);
      rdy_ready = 1'b0;
   endtask

   task automatic expect_none(input string tag);
      check(!rdy_valid, tag, out_now(), -1);
   endtask

   initial begin
      // sweep: op type x barrier state x predictor answer x register readiness
      for (int k = 0; k < 2; k++)
         for (int bm = 0; bm < 3; bm++)
            for (int pm = 0; pm < 3; pm++)
               for (int r = 0; r < 2; r++) begin
                  int pv, prod;
                  bit dep;
                  do_reset();
                  expect_none("R1 reset");
                  cmd(OP_INSERT, 10, 0, 1, 1'b0, 0);
                  if (bm == 1) cmd(OP_BARRIER, 20, 0, 2, 1'b0, 0);
                  if (bm == 2) cmd(OP_BARRIER, 20, 0, 3, 1'b0, 0);
                  pv   = (pm == 0) ? 0 : (pm == 1) ? 10 : 99;
                  prod = (k == 0 && bm == 1) ? 20 : (k == 1 && bm != 0) ? 20 : pv;
                  dep  = (prod == 10) || (prod == 20 && bm != 0);
                  cmd(OP_INSERT, 30, 0, k, r[0], pv);
                  if (!dep) begin
                     if (r != 0) expect_out(30, "R4 immediate");
                     else begin
                        expect_none("R4 regs pending");
                        cmd(OP_REGS_RDY, 30, 0, 0, 1'b0, 0);
                        expect_out(30, "R6 regs after mem");
                     end
                  end else begin
                     expect_none("R3 waits on producer");
                     if (r == 0) begin
                        cmd(OP_REGS_RDY, 30, 0, 0, 1'b0, 0);
                        expect_none("R6 mem not ready");
                     end
                     cmd(OP_COMPLETE, prod, 0, 0, 1'b0, 0);
                     expect_out(30, "R5 wake");
                  end
                  expect_none("R10 drained");
               end

      // barrier hand-over
      do_reset();
      cmd(OP_BARRIER, 20, 0, 2, 1'b0, 0);
      cmd(OP_BARRIER, 25, 0, 2, 1'b0, 0);
      cmd(OP_INSERT, 40, 0, 0, 1'b1, 0);
      expect_none("R2 load held by full barrier");
      cmd(OP_COMPLETE, 20, 0, 0, 1'b0, 0);
      expect_none("R7 older barrier leaves flag");
      cmd(OP_INSERT, 41, 0, 0, 1'b1, 0);
      expect_none("R7 flag still on younger barrier");
      cmd(OP_COMPLETE, 25, 0, 0, 1'b0, 0);
      expect_out(41, "R10 lowest slot first");
      expect_out(40, "R5 second waiter");
      cmd(OP_INSERT, 50, 0, 0, 1'b1, 0);
      expect_out(50, "R7 flag cleared");
      cmd(OP_BARRIER, 60, 0, 3, 1'b0, 0);
      cmd(OP_INSERT, 61, 0, 0, 1'b1, 0);
      expect_out(61, "R2 write barrier ignores load");
      cmd(OP_INSERT, 62, 0, 1, 1'b1, 0);
      expect_none("R2 write barrier holds store");
      cmd(OP_COMPLETE, 60, 0, 0, 1'b0, 0);
      expect_out(62, "R7 write barrier release");
      cmd(OP_INSERT, 70, 0, 0, 1'b0, 0);
      cmd(OP_INSERT, 71, 0, 1, 1'b1, 70);
      expect_out(71, "R4 load is no producer");

      // non-speculative
      cmd(OP_INSERT_NS, 80, 0, 0, 1'b1, 0);
      expect_none("R11 held");
      cmd(OP_REGS_RDY, 80, 0, 0, 1'b0, 0);
      expect_none("R11 regs do not release");
      cmd(OP_NS_GO, 80, 0, 0, 1'b0, 0);
      expect_out(80, "R11 go");

      // replay order
      do_reset();
      cmd(OP_INSERT, 101, 0, 0, 1'b0, 0);
      cmd(OP_INSERT, 102, 0, 0, 1'b0, 0);
      cmd(OP_INSERT, 103, 0, 0, 1'b0, 0);
      cmd(OP_RESCHED, 102, 0, 0, 1'b0, 0);
      cmd(OP_RESCHED, 103, 0, 0, 1'b0, 0);
      cmd(OP_RESCHED, 101, 0, 0, 1'b0, 0);
      expect_none("R8 queued only");
      cmd(OP_REPLAY, 0, 0, 0, 1'b0, 0);
      expect_out(102, "R8 first");
      expect_out(103, "R8 second");
      expect_out(101, "R8 third");
      expect_none("R8 empty");

      // squash
      do_reset();
      cmd(OP_INSERT, 200, 0, 0, 1'b0, 0);
      cmd(OP_INSERT, 201, 1, 0, 1'b0, 0);
      cmd(OP_INSERT, 205, 1, 0, 1'b0, 0);
      cmd(OP_INSERT, 210, 1, 0, 1'b0, 0);
      cmd(OP_INSERT, 211, 0, 0, 1'b0, 0);
      cmd(OP_RESCHED, 210, 1, 0, 1'b0, 0);
      cmd(OP_RESCHED, 200, 0, 0, 1'b0, 0);
      cmd(OP_SQUASH, 201, 1, 0, 1'b0, 0);
      cmd(OP_REPLAY, 0, 0, 0, 1'b0, 0);
      expect_out(200, "R9 replay survivor");
      expect_none("R9 squashed replay dropped");
      cmd(OP_REGS_RDY, 210, 1, 0, 1'b0, 0);
      expect_none("R9 210 removed");
      cmd(OP_REGS_RDY, 205, 1, 0, 1'b0, 0);
      expect_none("R9 205 removed");
      cmd(OP_REGS_RDY, 201, 1, 0, 1'b0, 0);
      expect_out(201, "R9 squash point kept");
      cmd(OP_REGS_RDY, 211, 0, 0, 1'b0, 0);
      expect_out(211, "R9 other thread kept");

      // hold while not accepted
      cmd(OP_INSERT, 300, 0, 0, 1'b1, 0);
      for (int c = 0; c < 3; c++) begin
         check(rdy_valid && rdy_seq == 16'd300, "R10 hold", out_now(), 300);
         @(negedge clk);
      end
      expect_out(300, "R10 accept");
      expect_none("R10 gone");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule